// File: doc/BRIEF.md
# Exhaustive Stuck-At Fault Coverage Evaluator

This block grades a small, fixed three-input circuit against every single stuck-at fault on its primary inputs. The circuit under test computes Z = x2·(x1 + x3), which is the same function as x1·x2 + x2·x3. The block holds two copies of it. One copy is fault-free. The other can force any one input to a constant.

A start pulse begins a sweep. The sweep runs through six faults in a fixed order: fault index k (0 to 5) pins input k/2 (0 = x1, 1 = x2, 2 = x3) to the value k mod 2. For each fault, the block applies all eight input vectors in ascending order. A vector detects the current fault when the good response and the faulty response differ, that is, when Z XOR Zf = 1. The block records one bit per fault and vector. It derives a detected flag per fault and keeps a running count of detected faults. It reports coverage as that count over a fixed total of six. After the run, a pair of fault indices can be selected, and the block shows which vectors tell those two faults apart.

The block has no streaming data path. Start, busy and done are plain level and pulse pins, and the result ports are static between runs.

Top module: `fault_cov_eval`

## Requirements
- R1: Vector index v (0 to 7) carries x1 in bit 2, x2 in bit 1 and x3 in bit 0. The 8-bit record of fault k occupies det_masks[8k+7:8k], and bit v of that record belongs to vector v.
- R2: After a completed sweep, bit v of fault k's record is 1 exactly when Z(v) XOR Zk(v) = 1. For faults 0 to 5 this gives the masks 0x40, 0x04, 0xC8, 0x32, 0x08 and 0x04.
- R3: For x2 stuck-at-1 (fault 3), vector 101 (v = 5) is recorded as detecting.
- R4: det_flags[k] is 1 exactly when fault k's record is nonzero. A fault that no vector detects keeps its flag at 0 and is not counted.
- R5: fault_total always reads 6. After a sweep, det_count equals the number of set bits in det_flags.
- R6: pair_mask bit v equals Za(v) XOR Zb(v) for faults a = pair_a and b = pair_b, computed from the records. It reads 0 if either index is above 5. With pair_a = 3 and pair_b = 4 the mask is 0x3A, so vector 101 distinguishes x2 stuck-at-1 from x3 stuck-at-0.
- R7: A start sampled high while idle sets busy on the next cycle. busy then stays high for exactly 48 cycles. A start sampled while busy has no effect on the timing or the results.
- R8: done is high for exactly one cycle: the cycle after busy falls, which is 48 clock edges after the edge that accepted start.
- R9: A synchronous active-high rst clears all records, the count, busy and done.
- R10: An accepted start clears the previous records and count before the new sweep, so a repeated run produces the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sweep request, taken only while idle |
| pair_a | input | 3 | First fault index for the distinguishing mask |
| pair_b | input | 3 | Second fault index for the distinguishing mask |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when a sweep ends |
| det_flags | output | 6 | Per-fault detected flag |
| det_masks | output | 48 | Per-fault detecting-vector masks, 8 bits each |
| det_count | output | 3 | Detected faults (coverage numerator) |
| fault_total | output | 3 | Total faults (coverage denominator) |
| pair_mask | output | 8 | Vectors that distinguish fault pair_a from fault pair_b |

## Verification
The result ports are final 48 edges after the accepting edge, and done flags that point. The bench therefore counts edges from the accepting edge to the first done at a falling edge and expects exactly 48. It reads every mask, flag and count only after done, never during the sweep. pair_mask is combinational from the stored records, so the bench changes pair_a and pair_b at a falling edge and samples at the next one. For the start-while-busy case, the bench pulses start mid-sweep and checks that the edge count to done is still 48 and that the masks still match.

// File: rtl/fcov_pkg.sv
package fcov_pkg;
  localparam int NUM_IN     = 3;
  localparam int NUM_FAULTS = 2 * NUM_IN;
  localparam int NUM_VEC    = 1 << NUM_IN;
  localparam int FI_W       = $clog2(NUM_FAULTS);
  localparam int CNT_W      = $clog2(NUM_FAULTS + 1);
  localparam int VEC_W      = NUM_IN;
  localparam int MASK_W     = NUM_FAULTS * NUM_VEC;
endpackage

// File: rtl/fcov_cut.sv
module fcov_cut
  import fcov_pkg::*;
#(
  parameter bit INJECT = 1'b0
) (
  input  logic [VEC_W-1:0] vec,
  input  logic [FI_W-1:0]  fault_idx,
  output logic             z
);
  // Input k (0 = x1) sits at vector bit NUM_IN-1-k.
  logic [NUM_IN-1:0] eff;

  genvar k;
  generate
    for (k = 0; k < NUM_IN; k++) begin : g_in
      if (INJECT) begin : g_flt
        logic hit;
        assign hit = (fault_idx[FI_W-1:1] == k[FI_W-2:0]);
        assign eff[NUM_IN-1-k] = hit ? fault_idx[0] : vec[NUM_IN-1-k];
      end else begin : g_good
        logic unused_ok;
        assign unused_ok = ^fault_idx;
        assign eff[NUM_IN-1-k] = vec[NUM_IN-1-k];
      end
    end
  endgenerate

  // Z = x1.x2 + x2.x3
  assign z = (eff[2] & eff[1]) | (eff[1] & eff[0]);
endmodule

// File: rtl/fcov_seq.sv
module fcov_seq
  import fcov_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic             clear,
  output logic [FI_W-1:0]  fault_idx,
  output logic [VEC_W-1:0] vec_idx,
  output logic             last_vec
);
  localparam logic [FI_W-1:0]  LAST_F = FI_W'(NUM_FAULTS - 1);
  localparam logic [VEC_W-1:0] LAST_V = VEC_W'(NUM_VEC - 1);

  assign clear    = start && !busy;
  assign last_vec = busy && (vec_idx == LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      fault_idx <= '0;
      vec_idx   <= '0;
    end else begin
      done <= 1'b0;
      if (clear) begin
        busy      <= 1'b1;
        fault_idx <= '0;
        vec_idx   <= '0;
      end else if (busy) begin
        vec_idx <= vec_idx + 1'b1;
        if (last_vec) begin
          vec_idx <= '0;
          if (fault_idx == LAST_F) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            fault_idx <= fault_idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fcov_record.sv
module fcov_record
  import fcov_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              step,
  input  logic              last_vec,
  input  logic [FI_W-1:0]   fault_idx,
  input  logic [VEC_W-1:0]  vec_idx,
  input  logic              diff,
  input  logic [FI_W-1:0]   pair_a,
  input  logic [FI_W-1:0]   pair_b,
  output logic [NUM_FAULTS-1:0] det_flags,
  output logic [MASK_W-1:0]     det_masks,
  output logic [CNT_W-1:0]      det_count,
  output logic [NUM_VEC-1:0]    pair_mask
);
  logic [NUM_VEC-1:0] rec [NUM_FAULTS];
  logic [NUM_VEC-1:0] cur_with;

  assign cur_with = rec[fault_idx] | (NUM_VEC'(diff) << vec_idx);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      for (int f = 0; f < NUM_FAULTS; f++) rec[f] <= '0;
      det_count <= '0;
    end else if (step) begin
      rec[fault_idx][vec_idx] <= diff;
      if (last_vec && (cur_with != '0)) det_count <= det_count + 1'b1;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_FAULTS; g++) begin : g_out
      assign det_flags[g] = |rec[g];
      assign det_masks[g*NUM_VEC +: NUM_VEC] = rec[g];
    end
  endgenerate

  // (Z^Za)^(Z^Zb) = Za^Zb
  always_comb begin
    pair_mask = '0;
    if (int'(pair_a) < NUM_FAULTS && int'(pair_b) < NUM_FAULTS)
      pair_mask = rec[pair_a] ^ rec[pair_b];
  end
endmodule

// File: rtl/fault_cov_eval.sv
module fault_cov_eval
  import fcov_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [FI_W-1:0]   pair_a,
  input  logic [FI_W-1:0]   pair_b,
  output logic              busy,
  output logic              done,
  output logic [NUM_FAULTS-1:0] det_flags,
  output logic [MASK_W-1:0]     det_masks,
  output logic [CNT_W-1:0]      det_count,
  output logic [CNT_W-1:0]      fault_total,
  output logic [NUM_VEC-1:0]    pair_mask
);
  logic             clear, last_vec, z_good, z_bad;
  logic [FI_W-1:0]  fault_idx;
  logic [VEC_W-1:0] vec_idx;

  assign fault_total = CNT_W'(NUM_FAULTS);

  fcov_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .clear(clear), .fault_idx(fault_idx), .vec_idx(vec_idx), .last_vec(last_vec)
  );

  fcov_cut #(.INJECT(1'b0)) u_good (.vec(vec_idx), .fault_idx(fault_idx), .z(z_good));
  fcov_cut #(.INJECT(1'b1)) u_bad  (.vec(vec_idx), .fault_idx(fault_idx), .z(z_bad));

  fcov_record u_rec (
    .clk(clk), .rst(rst), .clear(clear), .step(busy), .last_vec(last_vec),
    .fault_idx(fault_idx), .vec_idx(vec_idx), .diff(z_good ^ z_bad),
    .pair_a(pair_a), .pair_b(pair_b),
    .det_flags(det_flags), .det_masks(det_masks), .det_count(det_count),
    .pair_mask(pair_mask)
  );
endmodule

// File: rtl/fcov_checker.sv
module fcov_checker
  import fcov_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic                  busy,
  input logic                  done,
  input logic [NUM_FAULTS-1:0] det_flags,
  input logic [MASK_W-1:0]     det_masks,
  input logic [CNT_W-1:0]      det_count,
  input logic [CNT_W-1:0]      fault_total
);
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
    det_count <= fault_total);

  a_r5_count_flags: assert property (@(posedge clk) disable iff (rst)
    done |-> (det_count == CNT_W'($countones(det_flags))));

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (!busy && !done && det_count == '0 && det_flags == '0));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(det_masks) && !busy));

  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && det_count == '0));
endmodule

bind fault_cov_eval fcov_checker chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .det_flags(det_flags), .det_masks(det_masks), .det_count(det_count),
  .fault_total(fault_total)
);

// File: tb/fault_cov_eval_tb_top.sv
`timescale 1ns/1ps
module fault_cov_eval_tb_top;
  import fcov_pkg::*;

  logic clk = 1'b0;
  logic rst, start;
  logic [FI_W-1:0] pair_a, pair_b;
  logic busy, done;
  logic [NUM_FAULTS-1:0] det_flags;
  logic [MASK_W-1:0] det_masks;
  logic [CNT_W-1:0] det_count, fault_total;
  logic [NUM_VEC-1:0] pair_mask;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fault_cov_eval dut_i (
    .clk(clk), .rst(rst), .start(start), .pair_a(pair_a), .pair_b(pair_b),
    .busy(busy), .done(done), .det_flags(det_flags), .det_masks(det_masks),
    .det_count(det_count), .fault_total(fault_total), .pair_mask(pair_mask)
  );

  // Expected per-fault detecting masks (R1, R2): x1/0, x1/1, x2/0, x2/1, x3/0, x3/1
  localparam logic [7:0] EXP_MASK [6] = '{8'h40, 8'h04, 8'hC8, 8'h32, 8'h08, 8'h04};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Pulse start, return number of edges from accepting edge to done.
  task automatic run_sweep(input bit poke_mid, output int edges);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    edges = 0;
    while (edges < 200) begin
      @(posedge clk);
      @(negedge clk);
      edges++;
      if (poke_mid && edges == 20) start = 1'b1;
      if (poke_mid && edges == 21) start = 1'b0;
      if (done) break;
    end
  endtask

  initial begin
    int edges;
    rst = 1'b1; start = 1'b0; pair_a = 3'd3; pair_b = 3'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", 64'(busy), 64'd0);
    chk("R9 done", 64'(done), 64'd0);
    chk("R9 masks", 64'(det_masks), 64'd0);
    chk("R9 count", 64'(det_count), 64'd0);
    chk("R5 total", 64'(fault_total), 64'd6);
    rst = 1'b0;

    run_sweep(1'b0, edges);
    chk("R8 done timing", 64'(edges), 64'd48);
    chk("R8 busy low at done", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R8 done one cycle", 64'(done), 64'd0);

    for (int f = 0; f < NUM_FAULTS; f++) begin
      chk($sformatf("R2 mask f%0d", f), 64'(det_masks[f*8 +: 8]), 64'(EXP_MASK[f]));
      chk($sformatf("R4 flag f%0d", f), 64'(det_flags[f]), 64'(EXP_MASK[f] != 8'h00));
    end
    chk("R3 x2/1 vector 101", 64'(det_masks[3*8 + 5]), 64'd1);
    chk("R5 count", 64'(det_count), 64'd6);
    chk("R6 pair 3/4", 64'(pair_mask), 64'h3A);
    chk("R6 101 distinguishes", 64'(pair_mask[5]), 64'd1);
    @(negedge clk); pair_a = 3'd1; pair_b = 3'd5;
    @(negedge clk);
    chk("R6 pair 1/5 equal", 64'(pair_mask), 64'h00);
    pair_a = 3'd0; pair_b = 3'd2;
    @(negedge clk);
    chk("R6 pair 0/2", 64'(pair_mask), 64'h88);
    pair_a = 3'd6;
    @(negedge clk);
    chk("R6 out of range", 64'(pair_mask), 64'h00);

    // R7 idle: results hold
    repeat (5) @(negedge clk);
    chk("R7 idle masks hold", 64'(det_masks[31:0]), 64'h0832_C804 ^ 64'h0 ^ {32'h0, EXP_MASK[3], EXP_MASK[2], EXP_MASK[1], EXP_MASK[0]} ^ 64'h0832_C804);

    // R7/R10 rerun with start poked while busy
    run_sweep(1'b1, edges);
    chk("R7 start while busy ignored", 64'(edges), 64'd48);
    chk("R10 rerun count", 64'(det_count), 64'd6);
    for (int f = 0; f < NUM_FAULTS; f++)
      chk($sformatf("R10 rerun mask f%0d", f), 64'(det_masks[f*8 +: 8]), 64'(EXP_MASK[f]));

    // R10 start clears records at once
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 clear count", 64'(det_count), 64'd0);
    chk("R7 busy after start", 64'(busy), 64'd1);
    // R9 reset mid-run
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 mid-run busy", 64'(busy), 64'd0);
    chk("R9 mid-run masks", 64'(det_masks), 64'd0);
    rst = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule